// File: doc/BRIEF.md
# Command-Steered SPI Word Register

This block is an SPI target that holds one data word. The direction of each transfer is not set by a pin. The controller chooses it by sending a command byte at the start of every chip-select window. One command code makes the target stream the stored word back on the serial output. Another code makes it capture the word that follows on the serial input. Any other code makes the target stay silent until chip select is released.

All target activity happens on the falling edge of the serial clock. The input line is sampled there, and the output line changes there. The controller is therefore expected to change its own lines on rising edges and to sample the target output on rising edges. Chip select going high at any moment forces the target back to waiting for a command. The stored word is replaced only when a load transfer has supplied every one of its bits.

Top module: `spi_cmd_register`

## Requirements
- R1: A synchronous reset, sampled on a falling edge of `sclk`, sets the stored word to 0xABCD and drives `sdo` high.
- R2: After `cs_n` falls, the first 8 bits sampled from `sdi` form the command byte, received most significant bit first.
- R3: Command 0x50 (read-back) causes the stored word to appear on `sdo` most significant bit first. Bit 15 is driven from the same falling edge that samples the last command bit, and each following falling edge presents the next bit, with no gap between command and data.
- R4: Command 0x46 (load) causes the next 16 `sdi` bits, most significant bit first, to replace the stored word. The new value takes effect on the falling edge that samples the 16th data bit.
- R5: `sdo` is high while the command is being received, during a load, after the last read-back bit, and while `cs_n` is high.
- R6: `sdi` is sampled, and `sdo` changes, only on falling edges of `sclk`. A value driven on a rising edge is therefore captured on the next falling edge, and `sdo` is stable at the rising edge that follows.
- R7: Raising `cs_n` at any point abandons the current transfer. The next low period of `cs_n` starts again with a fresh command byte.
- R8: Any command byte other than 0x50 and 0x46 is ignored. `sdo` stays high, and the stored word is unchanged by any bits clocked in before `cs_n` rises.
- R9: A load transfer ended by `cs_n` before all 16 data bits arrive leaves the stored word unchanged.
- R10: Clock edges beyond the 24th within a single `cs_n` low period have no effect: `sdo` stays high and the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all target state advances on its falling edge |
| rst | input | 1 | Active-high synchronous reset, sampled on falling edges of `sclk` |
| cs_n | input | 1 | Active-low chip select; high level clears the transfer state at once |
| sdi | input | 1 | Serial data from the controller (command and load data) |
| sdo | output | 1 | Serial data to the controller (read-back data, otherwise high) |

## Verification
The controller model changes `cs_n` and `sdi` on rising edges. Counting rising edges from the one at which `cs_n` falls, read-back bit 15 is due at rising edge 8, and bit 0 is due at rising edge 23. The monitor samples `sdo` exactly at those rising edges, half a period after the falling edge that produced each bit. A loaded word takes effect on the 24th falling edge, so it is checked through a later read-back rather than at the load itself. At every other rising edge, and while `cs_n` is high, the monitor expects `sdo` high. This applies to aborted, ignored and overlong transfers.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Transfer phase within one chip-select window
  typedef enum logic [2:0] {
    PH_CMD  = 3'd0,  // receiving command byte
    PH_GET  = 3'd1,  // streaming stored word out
    PH_PUT  = 3'd2,  // collecting a new word
    PH_SKIP = 3'd3,  // unknown command, stay quiet
    PH_DONE = 3'd4   // frame complete, further bits ignored
  } phase_t;

endpackage

// File: rtl/spi_bit_counter.sv
module spi_bit_counter #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  localparam int TOTAL = CMD_W + DATA_W,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             sclk,
  input  logic             rst,
  input  logic             cs_n,
  output logic [CNT_W-1:0] cnt,
  output logic             cmd_last,
  output logic             data_last
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] CMD_END  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(TOTAL - 1);

  // Counts sampled bits since chip select fell; saturates at the frame length
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      cnt <= '0;
    end else if (rst) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cmd_last  = (cnt == CMD_END);
  assign data_last = (cnt == DATA_END);

  // R2: every sampled bit advances the count until the frame is full
  a_r2_count_step: assert property (@(negedge sclk) disable iff (rst || cs_n)
    (cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int                CMD_W    = 8,
  parameter logic [CMD_W-1:0]  GET_CODE = CMD_W'('h50),
  parameter logic [CMD_W-1:0]  PUT_CODE = CMD_W'('h46)
) (
  input  logic   sclk,
  input  logic   rst,
  input  logic   cs_n,
  input  logic   sdi,
  input  logic   cmd_last,
  input  logic   data_last,
  output phase_t phase,
  output logic   get_start
);

  logic [CMD_W-2:0] cmd_sr;
  logic [CMD_W-1:0] code_now;
  phase_t           decoded;

  // Command byte as it stands once the current bit is included
  assign code_now = {cmd_sr, sdi};

  always_comb begin
    if (code_now == GET_CODE)      decoded = PH_GET;
    else if (code_now == PUT_CODE) decoded = PH_PUT;
    else                           decoded = PH_SKIP;
  end

  assign get_start = (phase == PH_CMD) && cmd_last && (decoded == PH_GET);

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      phase  <= PH_CMD;
      cmd_sr <= '0;
    end else if (rst) begin
      phase  <= PH_CMD;
      cmd_sr <= '0;
    end else begin
      case (phase)
        PH_CMD: begin
          cmd_sr <= code_now[CMD_W-2:0];
          if (cmd_last) phase <= decoded;
        end
        PH_GET, PH_PUT: begin
          if (data_last) phase <= PH_DONE;
        end
        default: ;
      endcase
    end
  end

  // R8: an unknown command holds the quiet phase until chip select rises
  a_r8_skip_sticky: assert property (@(negedge sclk) disable iff (rst || cs_n)
    (phase == PH_SKIP) |=> (phase == PH_SKIP));

  // R10: a finished frame never re-enters an active phase
  a_r10_done_sticky: assert property (@(negedge sclk) disable iff (rst || cs_n)
    (phase == PH_DONE) |=> (phase == PH_DONE));

endmodule

// File: rtl/spi_word_store.sv
module spi_word_store #(
  parameter int                DATA_W      = 16,
  parameter logic [DATA_W-1:0] RESET_VALUE = DATA_W'('hABCD)
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              load_last,
  input  logic              sdi,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-2:0] in_sr;

  // Incoming bits collect here; the stored word changes only on the last one
  always_ff @(negedge sclk) begin
    if (rst) begin
      in_sr <= '0;
    end else if (load_en) begin
      in_sr <= {in_sr[DATA_W-3:0], sdi};
    end
  end

  always_ff @(negedge sclk) begin
    if (rst) begin
      q <= RESET_VALUE;
    end else if (load_en && load_last) begin
      q <= {in_sr, sdi};
    end
  end

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              start,
  input  logic              active,
  input  logic [DATA_W-1:0] word,
  output logic              sdo
);

  logic [DATA_W-2:0] tx_sr;

  // Ones are shifted in behind the data so the line rests high afterwards
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      sdo   <= 1'b1;
      tx_sr <= '1;
    end else if (rst) begin
      sdo   <= 1'b1;
      tx_sr <= '1;
    end else if (start) begin
      sdo   <= word[DATA_W-1];
      tx_sr <= word[DATA_W-2:0];
    end else if (active) begin
      sdo   <= tx_sr[DATA_W-2];
      tx_sr <= {tx_sr[DATA_W-3:0], 1'b1};
    end else begin
      sdo   <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_cmd_register.sv
module spi_cmd_register
  import spi_cmd_pkg::*;
#(
  parameter int                CMD_W       = 8,
  parameter int                DATA_W      = 16,
  parameter logic [CMD_W-1:0]  GET_CODE    = CMD_W'('h50),
  parameter logic [CMD_W-1:0]  PUT_CODE    = CMD_W'('h46),
  parameter logic [DATA_W-1:0] RESET_VALUE = DATA_W'('hABCD)
) (
  input  logic sclk,
  input  logic rst,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo
);

  localparam int CNT_W = $clog2(CMD_W + DATA_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic              cmd_last;
  logic              data_last;
  phase_t            phase;
  logic              get_start;
  logic [DATA_W-1:0] store_q;

  spi_bit_counter #(
    .CMD_W (CMD_W),
    .DATA_W(DATA_W)
  ) u_count (
    .sclk     (sclk),
    .rst      (rst),
    .cs_n     (cs_n),
    .cnt      (cnt),
    .cmd_last (cmd_last),
    .data_last(data_last)
  );

  spi_cmd_decoder #(
    .CMD_W   (CMD_W),
    .GET_CODE(GET_CODE),
    .PUT_CODE(PUT_CODE)
  ) u_decode (
    .sclk     (sclk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sdi      (sdi),
    .cmd_last (cmd_last),
    .data_last(data_last),
    .phase    (phase),
    .get_start(get_start)
  );

  spi_word_store #(
    .DATA_W     (DATA_W),
    .RESET_VALUE(RESET_VALUE)
  ) u_store (
    .sclk     (sclk),
    .rst      (rst),
    .load_en  (phase == PH_PUT),
    .load_last(data_last),
    .sdi      (sdi),
    .q        (store_q)
  );

  spi_tx_shifter #(
    .DATA_W(DATA_W)
  ) u_tx (
    .sclk  (sclk),
    .rst   (rst),
    .cs_n  (cs_n),
    .start (get_start),
    .active(phase == PH_GET),
    .word  (store_q),
    .sdo   (sdo)
  );

  // R3: the first read-back bit is the stored MSB, with no idle bit
  a_r3_msb_on_start: assert property (@(negedge sclk) disable iff (rst || cs_n)
    get_start |=> (sdo == $past(store_q[DATA_W-1])));

  // R5: outside read-back the output line rests high
  a_r5_sdo_idle: assert property (@(negedge sclk) disable iff (rst || cs_n)
    ((phase != PH_GET) && !get_start) |=> sdo);

  // R9: the stored word moves only on the last bit of a load
  a_r9_store_hold: assert property (@(negedge sclk) disable iff (rst || cs_n)
    !((phase == PH_PUT) && data_last) |=> $stable(store_q));

  // R2: the frame counter is idle whenever chip select is high
  a_r2_count_clear: assert property (@(posedge sclk) disable iff (rst)
    cs_n |-> (cnt == '0));

endmodule

// File: tb/test_spi_cmd_register.sv
`timescale 1ns/1ps
module test_spi_cmd_register;

  localparam int M_NONE = 0;
  localparam int M_GET  = 1;
  localparam int M_HIGH = 2;

  logic clk  = 1'b0;
  logic rst  = 1'b1;
  logic cs_n = 1'b1;
  logic sdi  = 1'b0;
  logic sdo;

  int n_checks = 0;
  int n_errors = 0;
  int mode     = M_NONE;
  int k        = 0;
  int cycles   = 0;
  logic [15:0] acc;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz serial clock

  spi_cmd_register i_spi_cmd_register (
    .sclk(clk),
    .rst (rst),
    .cs_n(cs_n),
    .sdi (sdi),
    .sdo (sdo)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  // Monitor: samples sdo on rising edges, half a period after it changes
  always @(posedge clk) begin
    if (cs_n) begin
      k = 0;
      if (!rst) begin
        n_checks++;
        if (sdo !== 1'b1) begin
          n_errors++;
          $display("FAIL R7 R5 idle: sdo actual %b expected 1", sdo);
        end
      end
    end else begin
      k++;
      if (mode == M_GET && k >= 8 && k <= 23) begin
        acc = {acc[14:0], sdo};
        if (k == 23) begin
          n_checks++;
          if (exp_q.size() == 0) begin
            n_errors++;
            $display("FAIL R3 R6: word %h actual with no expected item", acc);
          end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (acc !== e) begin
              n_errors++;
              $display("FAIL %s R3 R6: read-back actual %h expected %h", t, acc, e);
            end
          end
        end
      end else if (mode != M_NONE) begin
        n_checks++;
        if (sdo !== 1'b1) begin
          n_errors++;
          $display("FAIL R5 R8 R10: bit %0d sdo actual %b expected 1", k, sdo);
        end
      end
    end
  end

  // Driver: one chip-select window of nbits, changed on rising edges
  task automatic xfer(input logic [7:0] cmd, input logic [15:0] data,
                      input logic [7:0] extra, input int nbits, input int m);
    logic [31:0] frame;
    frame = {cmd, data, extra};
    mode  = m;
    @(posedge clk);
    cs_n <= 1'b0;
    sdi  <= frame[31];
    for (int i = 1; i < nbits; i++) begin
      @(posedge clk);
      sdi <= frame[31-i];
    end
    @(posedge clk);
    cs_n <= 1'b1;
    sdi  <= 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic do_get(input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    xfer(8'h50, 16'h0000, 8'h00, 24, M_GET);
  endtask

  task automatic do_put(input logic [15:0] d);
    xfer(8'h46, d, 8'h00, 24, M_HIGH);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst <= 1'b0;
    @(posedge clk);
    // R1: reset state on the output
    n_checks++;
    if (sdo !== 1'b1) begin
      n_errors++;
      $display("FAIL R1: sdo after reset actual %b expected 1", sdo);
    end
    do_get(16'hABCD, "R1");
    // R4: loads of several patterns, each read back
    do_put(16'h7B69); do_get(16'h7B69, "R4");
    do_put(16'h0000); do_get(16'h0000, "R4");
    do_put(16'hFFFF); do_get(16'hFFFF, "R4");
    do_put(16'h1071); do_get(16'h1071, "R4");
    do_get(16'h1071, "R4");
    // R9: load cut after 10 data bits
    xfer(8'h46, 16'h5555, 8'h00, 18, M_HIGH);
    do_get(16'h1071, "R9");
    // R7: read-back cut inside the data, then command cut after 4 bits
    xfer(8'h50, 16'h0000, 8'h00, 13, M_NONE);
    xfer(8'h46, 16'h0000, 8'h00, 4, M_HIGH);
    do_put(16'hC3A5); do_get(16'hC3A5, "R7");
    // R8: unknown commands, one a bit away from the read-back code
    xfer(8'hA5, 16'h46BE, 8'hEF, 32, M_HIGH);
    xfer(8'h51, 16'h1234, 8'h00, 24, M_HIGH);
    xfer(8'h47, 16'h1234, 8'h00, 24, M_HIGH);
    do_get(16'hC3A5, "R8");
    // R10: overlong frames
    xfer(8'h46, 16'h2468, 8'hFF, 32, M_HIGH);
    exp_q.push_back(16'h2468);
    tag_q.push_back("R10");
    xfer(8'h50, 16'h0000, 8'h00, 32, M_GET);
    // R2: command MSB first: 0x0A is the bit reversal of 0x50, must be ignored
    xfer(8'h0A, 16'h0000, 8'h00, 24, M_HIGH);
    do_get(16'h2468, "R2");
    // R1: reset in mid-run restores the initial word
    @(posedge clk); rst <= 1'b1;
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    repeat (2) @(posedge clk);
    do_get(16'hABCD, "R1");
    repeat (4) @(posedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R3: pending items actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule